// File: doc/BRIEF.md
# Dual-Clock Configurable-Width Memory Block

This block is a 256-bit memory with one write port and one read port. Each port has its own clock, and the two clocks need not be related. A static geometry input sets how the storage is organised. In wide geometry the memory holds 32 words of 8 bits. In narrow geometry it holds 64 words of 4 bits. Both address buses are 6 bits wide and both data buses are 8 bits wide in either geometry. The geometry decides which address bits and which data lanes take part.

Each port has a polarity input that chooses the clock edge the port acts on. Writes take place on the active write edge when the write enable is high. Reads capture the addressed word into an output register on the active read edge when the read enable is high.

Internally the storage is 32 rows of 8 bits. In narrow geometry, address bit 5 picks one half of a row: high selects bits 7:4 and low selects bits 3:0. There are no states. The only sequential elements are the storage array and the read-data register.

Top module: `dpram_geom_top`

## Requirements
- R1: In wide geometry (`geom_x4`=0), a write with `we` high on the active write edge stores `wdata[7:0]` into row `waddr[4:0]`, and a later read of that row returns the whole byte.
- R2: In wide geometry, address bit 5 is ignored on both ports. Addresses that differ only in bit 5 reach the same row.
- R3: In narrow geometry (`geom_x4`=1), a write stores `wdata[3:0]` into bits 7:4 of row `waddr[4:0]` when `waddr[5]`=1, and into bits 3:0 when `waddr[5]`=0. The other half of the row keeps its value, and `wdata[7:4]` has no effect.
- R4: In narrow geometry, a read returns the selected half-row (chosen by `raddr[5]` the same way as in R3) on `rdata[3:0]` and drives `rdata[7:4]` to zero.
- R5: `rdata` changes only on an active read edge with `re` high. With `re` low, `rdata` holds its value.
- R6: A polarity input of 0 makes its port act on the rising edge of its clock, and 1 makes it act on the falling edge. The two ports choose their edges independently.
- R7: With `we` low, an active write edge leaves the storage unchanged.
- R8: While `rst_n` is low, `rdata` is 0. The reset takes effect without waiting for a clock edge and does not clear the storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the read-data register |
| geom_x4 | input | 1 | Geometry: 0 = 32x8, 1 = 64x4 (static) |
| wclk | input | 1 | Write port clock |
| wclk_inv | input | 1 | Write clock polarity: 0 rising, 1 falling |
| we | input | 1 | Write enable |
| waddr | input | 6 | Write address |
| wdata | input | 8 | Write data |
| rclk | input | 1 | Read port clock |
| rclk_inv | input | 1 | Read clock polarity: 0 rising, 1 falling |
| re | input | 1 | Read enable |
| raddr | input | 6 | Read address |
| rdata | output | 8 | Registered read data |

## Verification
The storage is first filled with distinct bytes so that every row has a known value. A directed write and read that differ only in address bit 5 then separates correct masking in wide geometry from an address that wraps to another row. Random traffic follows with both enables toggling and full-range addresses and data, in all eight combinations of geometry and the two polarities. The two clocks run at unrelated periods. Narrow-geometry traffic shows whether the lane select, the preservation of the untouched half-row and the zero upper output are right. The inverted-polarity runs show whether each port really follows its own edge choice. A final reset pulse in the middle of operation, followed by reads, separates clearing the output register from clearing the memory.

// File: rtl/dpram_geom_pkg.sv
package dpram_geom_pkg;
    typedef enum logic {
        GEOM_X8 = 1'b0,
        GEOM_X4 = 1'b1
    } geom_e;
endpackage

// File: rtl/dpram_addr_map.sv
module dpram_addr_map
    import dpram_geom_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  geom_e             geom_i,
    output logic [ADDR_W-2:0] row_o,
    output logic              upper_o
);
    // The low bits always pick the row; the top bit picks a half only in narrow geometry
    always_comb begin
        row_o   = addr_i[ADDR_W-2:0];
        upper_o = (geom_i == GEOM_X4) && addr_i[ADDR_W-1];
    end

    // R2: in wide geometry the half select must stay inactive
    always_comb begin
        if (geom_i == GEOM_X8) begin
            a_r2_top_bit_unused: assert (upper_o == 1'b0);
        end
    end
endmodule

// File: rtl/dpram_wr_lanes.sv
module dpram_wr_lanes
    import dpram_geom_pkg::*;
#(
    parameter int ROW_W = 8
) (
    input  geom_e             geom_i,
    input  logic              upper_i,
    input  logic [ROW_W-1:0]  wdata_i,
    output logic [1:0]        lane_en_o,
    output logic [ROW_W-1:0]  lane_data_o
);
    localparam int LW = ROW_W / 2;

    for (genvar l = 0; l < 2; l++) begin : g_lane
        always_comb begin
            if (geom_i == GEOM_X8) begin
                lane_en_o[l]             = 1'b1;
                lane_data_o[l*LW +: LW]  = wdata_i[l*LW +: LW];
            end else begin
                lane_en_o[l]             = (upper_i == (l == 1));
                lane_data_o[l*LW +: LW]  = wdata_i[LW-1:0];
            end
        end
    end

    // R3: narrow geometry writes exactly one half-row
    always_comb begin
        if (geom_i == GEOM_X4) begin
            a_r3_single_lane: assert ($onehot(lane_en_o));
        end
    end
endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
    parameter int ROWS  = 32,
    parameter int ROW_W = 8
) (
    input  logic                     wclk_eff,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [$clog2(ROWS)-1:0]  wrow_i,
    input  logic [1:0]               lane_en_i,
    input  logic [ROW_W-1:0]         lane_data_i,
    input  logic [$clog2(ROWS)-1:0]  rrow_i,
    output logic [ROW_W-1:0]         rrow_data_o
);
    localparam int LW = ROW_W / 2;

    logic [ROW_W-1:0] mem [ROWS];

    always_ff @(posedge wclk_eff) begin
        if (we_i) begin
            for (int l = 0; l < 2; l++) begin
                if (lane_en_i[l]) begin
                    mem[wrow_i][l*LW +: LW] <= lane_data_i[l*LW +: LW];
                end
            end
        end
    end

    assign rrow_data_o = mem[rrow_i];

    // R1: a full-row write leaves the new byte in the row
    a_r1_row_written: assert property (@(posedge wclk_eff) disable iff (!rst_n)
        (we_i && (&lane_en_i)) |=> mem[$past(wrow_i)] == $past(lane_data_i));

    // R3: a low-half write keeps the high half
    a_r3_low_keeps_high: assert property (@(posedge wclk_eff) disable iff (!rst_n)
        (we_i && lane_en_i == 2'b01)
        |=> mem[$past(wrow_i)][ROW_W-1 -: LW] == $past(mem[wrow_i][ROW_W-1 -: LW]));

    // R3: a high-half write keeps the low half
    a_r3_high_keeps_low: assert property (@(posedge wclk_eff) disable iff (!rst_n)
        (we_i && lane_en_i == 2'b10)
        |=> mem[$past(wrow_i)][LW-1:0] == $past(mem[wrow_i][LW-1:0]));

    // R7: no enable, no change at the written row
    a_r7_idle_no_write: assert property (@(posedge wclk_eff) disable iff (!rst_n)
        !we_i |=> mem[$past(wrow_i)] == $past(mem[wrow_i]));
endmodule

// File: rtl/dpram_rd_port.sv
module dpram_rd_port
    import dpram_geom_pkg::*;
#(
    parameter int ROW_W = 8
) (
    input  logic              rclk_eff,
    input  logic              rst_n,
    input  geom_e             geom_i,
    input  logic              re_i,
    input  logic              upper_i,
    input  logic [ROW_W-1:0]  row_data_i,
    output logic [ROW_W-1:0]  rdata_o
);
    localparam int LW = ROW_W / 2;

    logic [ROW_W-1:0] rd_next;
    logic [ROW_W-1:0] rd_q;

    always_comb begin
        unique case (geom_i)
            GEOM_X8: rd_next = row_data_i;
            GEOM_X4: rd_next = {{LW{1'b0}},
                                upper_i ? row_data_i[ROW_W-1 -: LW] : row_data_i[LW-1:0]};
            default: rd_next = row_data_i;
        endcase
    end

    always_ff @(posedge rclk_eff or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (re_i) begin
            rd_q <= rd_next;
        end
    end

    assign rdata_o = rd_q;

    // R4: narrow reads leave the upper lane at zero
    a_r4_upper_zero: assert property (@(posedge rclk_eff) disable iff (!rst_n)
        (re_i && geom_i == GEOM_X4) |=> rd_q[ROW_W-1 -: LW] == '0);

    // R5: output holds without a read enable
    a_r5_hold: assert property (@(posedge rclk_eff) disable iff (!rst_n)
        !re_i |=> $stable(rd_q));
endmodule

// File: rtl/dpram_geom_top.sv
module dpram_geom_top
    import dpram_geom_pkg::*;
#(
    parameter int ROWS  = 32,
    parameter int ROW_W = 8,
    parameter int ADDR_W = $clog2(ROWS) + 1
) (
    input  logic              rst_n,
    input  logic              geom_x4,
    input  logic              wclk,
    input  logic              wclk_inv,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [ROW_W-1:0]  wdata,
    input  logic              rclk,
    input  logic              rclk_inv,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [ROW_W-1:0]  rdata
);
    localparam int ROW_AW = $clog2(ROWS);

    geom_e              geom;
    logic               wclk_eff;
    logic               rclk_eff;
    logic [ROW_AW-1:0]  wrow;
    logic [ROW_AW-1:0]  rrow;
    logic               w_upper;
    logic               r_upper;
    logic [1:0]         lane_en;
    logic [ROW_W-1:0]   lane_data;
    logic [ROW_W-1:0]   rrow_data;

    assign geom     = geom_e'(geom_x4);
    // R6: polarity select flips which clock edge the port sees as rising
    assign wclk_eff = wclk ^ wclk_inv;
    assign rclk_eff = rclk ^ rclk_inv;

    dpram_addr_map #(.ADDR_W(ADDR_W)) u_wmap (
        .addr_i(waddr), .geom_i(geom), .row_o(wrow), .upper_o(w_upper)
    );

    dpram_addr_map #(.ADDR_W(ADDR_W)) u_rmap (
        .addr_i(raddr), .geom_i(geom), .row_o(rrow), .upper_o(r_upper)
    );

    dpram_wr_lanes #(.ROW_W(ROW_W)) u_lanes (
        .geom_i(geom), .upper_i(w_upper), .wdata_i(wdata),
        .lane_en_o(lane_en), .lane_data_o(lane_data)
    );

    dpram_store #(.ROWS(ROWS), .ROW_W(ROW_W)) u_store (
        .wclk_eff(wclk_eff), .rst_n(rst_n), .we_i(we), .wrow_i(wrow),
        .lane_en_i(lane_en), .lane_data_i(lane_data),
        .rrow_i(rrow), .rrow_data_o(rrow_data)
    );

    dpram_rd_port #(.ROW_W(ROW_W)) u_rd (
        .rclk_eff(rclk_eff), .rst_n(rst_n), .geom_i(geom), .re_i(re),
        .upper_i(r_upper), .row_data_i(rrow_data), .rdata_o(rdata)
    );
endmodule

// File: tb/dpram_geom_top_tb.sv
`timescale 1ns/100ps
module dpram_geom_top_tb;
    localparam int  WCLK_PERIOD = 10;
    localparam real RCLK_HALF   = 6.5;

    logic       rst_n, geom_x4, wclk, wclk_inv, we, rclk, rclk_inv, re;
    logic [5:0] waddr, raddr;
    logic [7:0] wdata, rdata;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    string tag    = "R8";

    logic [7:0] model [32];
    logic [7:0] exp_rd = 8'h00;
    logic       wck_eff, rck_eff;

    dpram_geom_top u_dut (
        .rst_n(rst_n), .geom_x4(geom_x4), .wclk(wclk), .wclk_inv(wclk_inv),
        .we(we), .waddr(waddr), .wdata(wdata), .rclk(rclk), .rclk_inv(rclk_inv),
        .re(re), .raddr(raddr), .rdata(rdata)
    );

    // Bench view of the active edges (R6)
    assign wck_eff = wclk ^ wclk_inv;
    assign rck_eff = rclk ^ rclk_inv;

    initial begin
        wclk = 0;
        forever #(WCLK_PERIOD/2) wclk = ~wclk;
    end

    initial begin
        rclk = 0;
        #1.3;
        forever #(RCLK_HALF) rclk = ~rclk;
    end

    // Reference write model: R1, R3, R7
    always @(posedge wck_eff) begin
        if (we === 1'b1) begin
            if (!geom_x4) model[waddr[4:0]] = wdata;
            else if (waddr[5]) model[waddr[4:0]][7:4] = wdata[3:0];
            else model[waddr[4:0]][3:0] = wdata[3:0];
        end
    end

    function automatic logic [7:0] ref_read(input logic [5:0] a);
        if (!geom_x4) return model[a[4:0]];
        return a[5] ? {4'h0, model[a[4:0]][7:4]} : {4'h0, model[a[4:0]][3:0]};
    endfunction

    task automatic check(input string t, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rdata=%h expected=%h at %0t", t, act, exp, $time);
        end
    endtask

    // Compare on every active read edge: R5 (hold when re low), R4, R8
    always begin
        @(posedge rck_eff or negedge rst_n);
        if (rst_n !== 1'b1) exp_rd = 8'h00;
        else if (re === 1'b1) exp_rd = ref_read(raddr);
        #1;
        if (!done) check(rst_n ? tag : "R8", rdata, exp_rd);
    end

    task automatic write_one(input logic [5:0] a, input logic [7:0] d);
        @(posedge wck_eff); #1;
        we = 1; waddr = a; wdata = d;
        @(posedge wck_eff); #1;
        we = 0;
    endtask

    task automatic read_one(input logic [5:0] a);
        @(posedge rck_eff); #1;
        re = 1; raddr = a;
        @(posedge rck_eff); #1;
        re = 0;
    endtask

    task automatic write_rand(input int n);
        repeat (n) begin
            @(posedge wck_eff); #1;
            we = 1'($urandom); waddr = 6'($urandom); wdata = 8'($urandom);
        end
        @(posedge wck_eff); #1;
        we = 0;
    endtask

    task automatic read_rand(input int n);
        repeat (n) begin
            @(posedge rck_eff); #1;
            re = 1'($urandom); raddr = 6'($urandom);
        end
        @(posedge rck_eff); #1;
        re = 0;
    endtask

    task automatic set_cfg(input logic g, input logic wi, input logic ri, input string t);
        we = 0; re = 0;
        #30;
        geom_x4 = g; wclk_inv = wi; rclk_inv = ri; tag = t;
        #30;
    endtask

    initial begin
        #(WCLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 8'h00;
        rst_n = 0; geom_x4 = 0; wclk_inv = 0; rclk_inv = 0;
        we = 0; re = 0; waddr = 0; raddr = 0; wdata = 0;
        #5;
        check("R8", rdata, 8'h00);   // R8: reset value
        #40;
        rst_n = 1;

        // R1: fill every row in wide geometry
        tag = "R1";
        for (int i = 0; i < 32; i++) write_one(6'(i), 8'(i * 37 + 11));
        for (int i = 0; i < 32; i += 5) read_one(6'(i));

        // R2: top address bit ignored in wide geometry
        tag = "R2";
        write_one(6'h25, 8'hA5);
        read_one(6'h05);
        check("R2", rdata, 8'hA5);
        write_one(6'h03, 8'h3C);
        read_one(6'h23);
        check("R2", rdata, 8'h3C);

        // R3/R4: directed half-row writes and reads
        set_cfg(1, 0, 0, "R3");
        write_one(6'h27, 8'hF9);     // upper half of row 7 gets 9
        write_one(6'h07, 8'hE2);     // lower half of row 7 gets 2
        read_one(6'h27);
        check("R4", rdata, 8'h09);
        read_one(6'h07);
        check("R4", rdata, 8'h02);

        // R7: disabled writes leave row 7 alone
        @(posedge wck_eff); #1;
        we = 0; waddr = 6'h27; wdata = 8'h0F;
        repeat (3) @(posedge wck_eff);
        read_one(6'h27);
        check("R7", rdata, 8'h09);

        // Random traffic over all geometries and polarities (R1 R3 R4 R5 R6 R7)
        for (int g = 0; g < 2; g++) begin
            for (int wi = 0; wi < 2; wi++) begin
                for (int ri = 0; ri < 2; ri++) begin
                    set_cfg(1'(g), 1'(wi), 1'(ri),
                            (wi || ri) ? "R6" : (g ? "R3" : "R1"));
                    fork
                        write_rand(150);
                        read_rand(120);
                    join
                end
            end
        end

        // R8: reset mid-run clears the output immediately, storage is kept
        set_cfg(0, 0, 0, "R8");
        read_one(6'h07);
        #3;
        rst_n = 0;
        #2;
        check("R8", rdata, 8'h00);
        #20;
        rst_n = 1;
        for (int i = 0; i < 32; i += 3) read_one(6'(i));

        #20;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule